// File: doc/BRIEF.md
# 22 kHz Tone Presence Detector

This block watches a one-bit signal that a comparator derives from a capacitively coupled satellite control bus. It reports, in clock-synchronous form, whether a 22 kHz carrier is currently on the line. The input passes through a two-flop synchronizer. One saturating counter then measures every full cycle of the square wave, from one rising edge to the next, in system clock cycles. Each measurement is compared against a window that corresponds to 20 kHz to 24 kHz.

A carrier is declared present after two back-to-back in-window cycles. It is declared gone when no rising edge has been seen for three nominal cycles. While the carrier is present, `tone_n_o` is pulled low; it is released (high) otherwise. This gives a host controller the demodulated envelope of a received burst. Two status bits go alongside it: `det_o` follows presence, and `mon_o` is a sticky flag that records a cycle measured outside the window while the carrier was present.

All timing is derived from the clock frequency and the tone limits given as parameters. Window bounds are MIN = CLK_HZ/TONE_HI_HZ and MAX = CLK_HZ/TONE_LO_HZ clock cycles (integer division). The timeout is TO = TIMEOUT_PERIODS*(CLK_HZ/TONE_NOM_HZ) cycles.

Top module: `tone_detector`

## Requirements
- R1: A rising edge driven on `det_in_i` just before clock edge k is first reflected on the outputs after clock edge k+2 (two synchronizer stages plus one output register); it has no effect on the outputs after edges k and k+1.
- R2: `det_o` becomes 1 once two consecutive measured cycles, rising edge to rising edge, each lie in [MIN, MAX] clock cycles. The inclusive bounds MIN and MAX are themselves accepted.
- R3: A single in-window cycle does not assert `det_o`. Cycles shorter than MIN or longer than MAX never count toward presence, and they restart the consecutive count.
- R4: `tone_n_o` is active low: it is 0 exactly when `det_o` is 1.
- R5: Once present, `det_o` stays 1 until TO clock cycles pass with no rising edge. It falls at clock edge k+2+TO when the last rising edge was driven just before edge k.
- R6: A cycle measured outside [MIN, MAX] while `det_o` is 1 sets `mon_o` to 1 and leaves `det_o` at 1.
- R7: `mon_o` stays 1 across gaps and through the timeout. It is cleared only on the clock edge where `det_o` next rises.
- R8: While `rst_ni` is 0, `det_o` and `mon_o` are 0 and `tone_n_o` is 1, with no clock edge needed.
- R9: With `det_in_i` held constant, low or high, for any length of time, `det_o` and `mon_o` stay 0 and `tone_n_o` stays 1.
- R10: The cycle counter saturates at TO and never wraps. A gap of any length longer than TO is never taken as an in-window cycle: after such a gap, only one further in-window cycle leaves `det_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_in_i | input | 1 | Comparator output from the bus, asynchronous |
| tone_n_o | output | 1 | Envelope, low while a carrier is present |
| det_o | output | 1 | Status: carrier present |
| mon_o | output | 1 | Status: carrier cycle seen out of limits (sticky) |

## Verification
A miscounted cycle length moves a carrier near the window edges across the accept boundary. The bench makes this visible at the ports within three clock cycles of the qualifying rising edge, through `det_o` and `tone_n_o`. A broken consecutive-cycle count or a wrapping counter makes `det_o` assert one edge early; a burst that is one cycle short, or a long gap, shows it. An error in the timeout or in the sticky monitor state only appears at the moment presence would drop or be re-acquired, so the bench checks those edges to the exact clock cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;
  function automatic int cyc_of(input int clk_hz, input int tone_hz);
    return clk_hz / tone_hz;
  endfunction
endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tone_period_meter.sv
module tone_period_meter #(
  parameter int CNT_MAX = 300,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  logic             sig_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o = sig_i & ~sig_q;
  assign sat_o  = (cnt_q == CNT_W'(CNT_MAX));
  assign cnt_o  = cnt_q;

  // reset to saturated: the first edge after reset yields no valid period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= 1'b0;
      cnt_q <= CNT_W'(CNT_MAX);
    end else begin
      sig_q <= sig_i;
      if (edge_o)      cnt_q <= CNT_W'(1);
      else if (!sat_o) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tone_qualifier.sv
module tone_qualifier #(
  parameter int CNT_W    = 9,
  parameter int MIN_CYC  = 91,
  parameter int MAX_CYC  = 110,
  parameter int RUN_NEED = 2,
  localparam int RUN_W   = $clog2(RUN_NEED + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             sat_i,
  output logic             present_o,
  output logic             mon_o
);
  logic             present_q, mon_q;
  logic [RUN_W-1:0] run_q, run_nx;
  logic             in_win;

  assign in_win = (meas_i >= CNT_W'(MIN_CYC)) && (meas_i <= CNT_W'(MAX_CYC));
  assign run_nx = (run_q == RUN_W'(RUN_NEED)) ? run_q : run_q + RUN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= 1'b0;
      mon_q     <= 1'b0;
      run_q     <= '0;
    end else if (sat_i) begin
      // silence for the full timeout: carrier gone, monitor kept
      present_q <= 1'b0;
      run_q     <= '0;
    end else if (edge_i) begin
      if (in_win) begin
        run_q <= run_nx;
        if (!present_q && run_nx == RUN_W'(RUN_NEED)) begin
          present_q <= 1'b1;
          mon_q     <= 1'b0;
        end
      end else begin
        run_q <= '0;
        if (present_q) mon_q <= 1'b1;
      end
    end
  end

  assign present_o = present_q;
  assign mon_o     = mon_q;
endmodule

// File: rtl/tone_detector.sv
module tone_detector #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int TONE_LO_HZ      = 20_000,
  parameter int TONE_HI_HZ      = 24_000,
  parameter int TONE_NOM_HZ     = 22_000,
  parameter int TIMEOUT_PERIODS = 3,
  parameter int RUN_NEED        = 2,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_in_i,
  output logic tone_n_o,
  output logic det_o,
  output logic mon_o
);
  import tone_pkg::*;

  localparam int MIN_CYC = cyc_of(CLK_HZ, TONE_HI_HZ);
  localparam int MAX_CYC = cyc_of(CLK_HZ, TONE_LO_HZ);
  localparam int TO_CYC  = TIMEOUT_PERIODS * cyc_of(CLK_HZ, TONE_NOM_HZ);
  localparam int CNT_W   = $clog2(TO_CYC + 1);

  logic             sig_s;
  logic             edge_w;
  logic             sat_w;
  logic [CNT_W-1:0] cnt_w;
  logic             present_w;

  tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (det_in_i),
    .q_o   (sig_s)
  );

  tone_period_meter #(.CNT_MAX(TO_CYC)) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_s),
    .edge_o(edge_w),
    .cnt_o (cnt_w),
    .sat_o (sat_w)
  );

  tone_qualifier #(
    .CNT_W   (CNT_W),
    .MIN_CYC (MIN_CYC),
    .MAX_CYC (MAX_CYC),
    .RUN_NEED(RUN_NEED)
  ) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (edge_w),
    .meas_i   (cnt_w),
    .sat_i    (sat_w),
    .present_o(present_w),
    .mon_o    (mon_o)
  );

  assign det_o    = present_w;
  assign tone_n_o = ~present_w;
endmodule

// File: rtl/tone_detector_chk.sv
module tone_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tone_n_o,
  input logic det_o,
  input logic mon_o,
  input logic edge_i,
  input logic sat_i
);
  p_polarity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_n_o == !det_o);

  p_rise_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(edge_i));

  p_fall_on_timeout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_o) |-> $past(sat_i));

  p_mon_while_present_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mon_o) |-> (det_o && $past(det_o)));

  p_mon_clear_on_acquire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mon_o) |-> $rose(det_o));

  always @(posedge clk_i)
    if (!rst_ni) p_reset_r8: assert (!det_o && !mon_o && tone_n_o);
endmodule

bind tone_detector tone_detector_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tone_n_o(tone_n_o),
  .det_o   (det_o),
  .mon_o   (mon_o),
  .edge_i  (edge_w),
  .sat_i   (sat_w)
);

// File: tb/sim_tone_detector.sv
module sim_tone_detector;
  // ratio parameter chosen so one nominal tone cycle is 100 clocks
  localparam int CLK_HZ = 2_200_000;
  localparam int MIN_C  = CLK_HZ / 24_000;       // 91
  localparam int MAX_C  = CLK_HZ / 20_000;       // 110
  localparam int TO_C   = 3 * (CLK_HZ / 22_000); // 300
  localparam int NV     = 8;
  // period, rising edges, expected det, expected mon
  localparam int VP[NV] = '{100, 100, MIN_C, MAX_C, MIN_C-1, MAX_C+1, 140, 100};
  localparam int VN[NV] = '{3,   2,   3,     3,     5,       5,       6,   12};
  localparam bit VD[NV] = '{1,   0,   1,     1,     0,       0,       0,   1};
  localparam bit VM[NV] = '{0,   0,   0,     0,     0,       0,       0,   0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic din = 1'b0;
  logic tone_n, det, mon;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  tone_detector #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .det_in_i(din),
    .tone_n_o(tone_n),
    .det_o   (det),
    .mon_o   (mon)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic exp_det, input logic exp_mon);
    chk(tag, "det_o", det, exp_det);
    chk(tag, "mon_o", mon, exp_mon);
    chk(tag, "tone_n_o", tone_n, ~exp_det);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n rising edges, p clocks apart; returns at the negedge that drove the last rise
  task automatic train(input int p, input int n);
    for (int i = 0; i < n - 1; i++) begin
      din = 1'b1;
      wait_n(p / 2);
      din = 1'b0;
      wait_n(p - p / 2);
    end
    din = 1'b1;
  endtask

  task automatic tail(input int p);
    wait_n(p / 2);
    din = 1'b0;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state, asynchronous
    #5;
    chk_out("R8", 1'b0, 1'b0);
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);

    // R9: input tied low
    wait_n(1000);
    chk_out("R9", 1'b0, 1'b0);

    // R2 R3 R4: table of periods and burst lengths
    for (int v = 0; v < NV; v++) begin
      wait_n(TO_C + 100);
      train(VP[v], VN[v]);
      tail(VP[v]);
      chk_out(VD[v] ? "R2" : "R3", VD[v], VM[v]);
    end

    // R1: exact acquisition latency
    wait_n(TO_C + 100);
    train(100, 3);
    wait_n(2);
    chk_out("R1", 1'b0, 1'b0);
    wait_n(1);
    chk_out("R1", 1'b1, 1'b0);

    // R5: exact timeout, counted from the last driven rise (3 clocks elapsed)
    wait_n(47);
    din = 1'b0;
    wait_n(TO_C + 2 - 50);
    chk("R5", "det_o before timeout", det, 1'b1);
    wait_n(1);
    chk("R5", "det_o at timeout", det, 1'b0);
    chk("R4", "tone_n_o at timeout", tone_n, 1'b1);

    // R6: out-of-window cycle (130 clocks) while present
    wait_n(TO_C + 100);
    train(100, 3);
    wait_n(3);
    chk_out("R6", 1'b1, 1'b0);
    wait_n(47);
    din = 1'b0;
    wait_n(80);
    train(100, 4);
    tail(100);
    chk_out("R6", 1'b1, 1'b1);

    // R7: monitor survives timeout, cleared by next acquisition
    wait_n(TO_C + 100);
    chk_out("R7", 1'b0, 1'b1);
    train(100, 2);
    tail(100);
    chk_out("R7", 1'b0, 1'b1);
    wait_n(50);
    train(100, 1);
    wait_n(3);
    chk_out("R7", 1'b1, 1'b0);
    tail(100);

    // R10: gap of 612 clocks (wraps a 9-bit counter to 100) then one valid cycle
    wait_n(TO_C + 100);
    train(100, 1);
    wait_n(50);
    din = 1'b0;
    wait_n(562);
    train(100, 2);
    tail(100);
    chk_out("R10", 1'b0, 1'b0);

    // R9: input held high
    wait_n(TO_C + 100);
    din = 1'b1;
    wait_n(1000);
    chk_out("R9", 1'b0, 1'b0);
    din = 1'b0;

    // R8: reset in the middle of a tone
    wait_n(TO_C + 100);
    train(100, 4);
    wait_n(10);
    chk("R8", "det_o before reset", det, 1'b1);
    rst_ni = 1'b0;
    #2;
    chk_out("R8", 1'b0, 1'b0);
    wait_n(3);
    rst_ni = 1'b1;
    tail(100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule